// File: doc/BRIEF.md
# Eight-Channel Event Interrupt Controller

This block collects event pulses from eight counter channels and turns them into a single shared interrupt request. Each channel drives a one-cycle pulse on its event input. The pulse is latched into a sticky status bit only when three conditions hold: the channel's enable bit is set, the interrupt function is armed, and the pulse arrives. The interrupt output is high while any status bit is set.

Software works through a byte-wide bus that decodes a 32-byte window. The status bits are not cleared one by one. A single command to the operation register arms the interrupt function, starts the counters and wipes every pending bit. A second command disarms the function and sends a one-cycle clear pulse to all counters.

The same window also holds two more bytes:
- an index-level byte, which reads the live index inputs;
- a cable byte. Writing it sets the cable-monitoring enables, where a zero enables monitoring. Reading it returns zero in each bit whose monitored cable has a fault.

Top module: `evt_irq_ctrl`

A small state machine holds the arming state. It has two states:
- `ST_DISARMED`, entered at reset and by `OP_RESET` (0x01).
- `ST_ARMED`, entered from either state by `OP_ARM` (0x04).

Its transitions are named DISARMED->ARMED on an arm write, ARMED->DISARMED on a reset write, and ARMED->ARMED on a re-arm write. A re-arm write clears the status bits again.

## Requirements
- R1: After reset the status byte (offset 0x10) reads 0x00, the enable byte (offset 0x12) reads 0x00 and the cable byte (offset 0x17) reads 0xFF. After reset `irq`, `cnt_run` and `cnt_clr` are low.
- R2: Status bit i (bit i of offset 0x10) is set at a clock edge only if all of the following hold at that edge: enable bit i is 1, `chan_evt[i]` is high and the function is armed. Once set, the bit stays set until the next arm write.
- R3: `irq` is high exactly when at least one status bit is set. It is low whenever the status byte reads zero.
- R4: Writing 0x04 to the operation register (offset 0x11) arms the function, drives `cnt_run` high and clears all status bits. These take effect at the clock edge of the write.
- R5: Writing 0x01 to the operation register does three things:
  - it disarms the function and drives `cnt_run` low;
  - it pulses `cnt_clr` high for the one cycle after the write;
  - it keeps the status bits already set, and later events are not latched.
- R6: Writing any value other than 0x01 or 0x04 to the operation register changes neither the arming state nor the status bits.
- R7: When an arm write and a channel event fall on the same edge, the clear wins and that event is dropped.
- R8: Writing the cable byte stores the per-channel monitoring enables, active low. Reading it gives, in bit i, 0 if monitoring of channel i is enabled and `cable_ok[i]` is low, and 1 otherwise.
- R9: The register map is:
  - offset 0x12 holds the enable byte, which can be written and read;
  - offset 0x16 returns `idx_level`;
  - offset 0x10 is read-only, and writes to it are ignored;
  - every other offset, including the channel pairs 0x00 to 0x0F, the operation register and the reserved bytes, reads 0x00 and ignores writes, except the commands of R4 and R5.
- R10: `bus_rdata` is loaded at the clock edge of a read access (`bus_sel` high, `bus_we` low) and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset in the 32-byte window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| chan_evt | input | 8 | Per-channel one-cycle event pulses |
| idx_level | input | 8 | Live index input levels |
| cable_ok | input | 8 | Per-channel cable good (1) / fault (0) |
| irq | output | 1 | Shared interrupt request |
| cnt_run | output | 1 | Counters and interrupt function enabled |
| cnt_clr | output | 1 | One-cycle clear pulse to all counters |

## Verification
The latching path is tested with a table of enable-mask and event-mask pairs. The pairs are full overlap, disjoint masks, partial overlap, a zero enable byte and scattered bit patterns, so that a dropped AND term, a swapped bit index or a lost enable shows up as a wrong status byte. Directed cases then cover the remaining behaviour:
- a disarm while a bit is pending, where the bit must stay and new events must be ignored;
- unknown operation codes;
- an event on the same edge as a clear;
- cable reads against chosen enable and fault patterns, which separate the active-low enable from the active-low fault report.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int EIC_AW = 5;
    localparam int EIC_DW = 8;

    localparam logic [EIC_AW-1:0] OFS_STATUS = 5'h10;
    localparam logic [EIC_AW-1:0] OFS_OPER   = 5'h11;
    localparam logic [EIC_AW-1:0] OFS_ENABLE = 5'h12;
    localparam logic [EIC_AW-1:0] OFS_INDEX  = 5'h16;
    localparam logic [EIC_AW-1:0] OFS_CABLE  = 5'h17;

    localparam logic [EIC_DW-1:0] OP_RESET = 8'h01;
    localparam logic [EIC_DW-1:0] OP_ARM   = 8'h04;

    typedef enum logic [0:0] {
        ST_DISARMED = 1'b0,
        ST_ARMED    = 1'b1
    } arm_state_e;
endpackage

// File: rtl/eic_arm_fsm.sv
module eic_arm_fsm
    import eic_pkg::*;
#(
    parameter int DW = EIC_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_wr,
    input  logic [DW-1:0] op_code,
    output logic          armed,
    output logic          clr_all,
    output logic          cnt_clr
);
    arm_state_e state_q, state_d;
    logic       is_arm, is_reset;

    always_comb begin
        is_arm   = op_wr && (op_code == DW'(OP_ARM));
        is_reset = op_wr && (op_code == DW'(OP_RESET));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISARMED: if (is_arm)   state_d = ST_ARMED;
            ST_ARMED:    if (is_reset) state_d = ST_DISARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DISARMED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        armed   = (state_q == ST_ARMED);
        clr_all = is_arm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_clr <= 1'b0;
        else        cnt_clr <= is_reset;
    end
endmodule

// File: rtl/eic_evt_latch.sv
module eic_evt_latch #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           armed,
    input  logic           clr_all,
    input  logic [NCH-1:0] en,
    input  logic [NCH-1:0] evt,
    output logic [NCH-1:0] status,
    output logic           irq
);
    generate
        for (genvar i = 0; i < NCH; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       status[i] <= 1'b0;
                else if (clr_all) status[i] <= 1'b0;
                else if (armed && en[i] && evt[i]) status[i] <= 1'b1;
            end
        end
    endgenerate

    assign irq = |status;
endmodule

// File: rtl/eic_bus_regs.sv
module eic_bus_regs
    import eic_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = EIC_AW,
    parameter int DW  = EIC_DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] status,
    input  logic [NCH-1:0] idx_level,
    input  logic [NCH-1:0] cable_ok,
    output logic [NCH-1:0] en,
    output logic           op_wr
);
    logic          wr, rd;
    logic [NCH-1:0] cab_en_n;
    logic [DW-1:0]  rd_mux;

    assign wr    = bus_sel && bus_we;
    assign rd    = bus_sel && !bus_we;
    assign op_wr = wr && (bus_addr == AW'(OFS_OPER));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en       <= '0;
            cab_en_n <= '1;
        end else if (wr) begin
            if (bus_addr == AW'(OFS_ENABLE)) en       <= bus_wdata[NCH-1:0];
            if (bus_addr == AW'(OFS_CABLE))  cab_en_n <= bus_wdata[NCH-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == AW'(OFS_STATUS)) rd_mux = DW'(status);
        if (bus_addr == AW'(OFS_ENABLE)) rd_mux = DW'(en);
        if (bus_addr == AW'(OFS_INDEX))  rd_mux = DW'(idx_level);
        if (bus_addr == AW'(OFS_CABLE))  rd_mux = DW'(cab_en_n | cable_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import eic_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = EIC_AW,
    parameter int DW  = EIC_DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] chan_evt,
    input  logic [NCH-1:0] idx_level,
    input  logic [NCH-1:0] cable_ok,
    output logic           irq,
    output logic           cnt_run,
    output logic           cnt_clr
);
    logic [NCH-1:0] en, status;
    logic           op_wr, armed, clr_all;

    eic_bus_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .status(status), .idx_level(idx_level), .cable_ok(cable_ok),
        .en(en), .op_wr(op_wr)
    );

    eic_arm_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .op_wr(op_wr), .op_code(bus_wdata),
        .armed(armed), .clr_all(clr_all), .cnt_clr(cnt_clr)
    );

    eic_evt_latch #(.NCH(NCH)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .armed(armed), .clr_all(clr_all),
        .en(en), .evt(chan_evt),
        .status(status), .irq(irq)
    );

    assign cnt_run = armed;
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk
    import eic_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = EIC_AW,
    parameter int DW  = EIC_DW
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_sel,
    input logic           bus_we,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_wdata,
    input logic [DW-1:0]  bus_rdata,
    input logic [NCH-1:0] chan_evt,
    input logic           irq,
    input logic           cnt_run,
    input logic           cnt_clr
);
    logic op_arm, op_rst;
    assign op_arm = bus_sel && bus_we && bus_addr == AW'(OFS_OPER) && bus_wdata == DW'(OP_ARM);
    assign op_rst = bus_sel && bus_we && bus_addr == AW'(OFS_OPER) && bus_wdata == DW'(OP_RESET);

    // R4: an arm write clears every pending bit
    a_r4_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        op_arm |=> (!irq && cnt_run));

    // R5: a reset write disarms and pulses the counter clear
    a_r5_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        op_rst |=> (cnt_clr && !cnt_run));

    // R5: the counter clear pulse only occurs while disarmed
    a_r5_clr_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |-> !cnt_run);

    // R2: nothing is latched while disarmed
    a_r2_no_latch_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_run && !irq) |=> !irq);

    // R2/R3: pending request is sticky until an arm write
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !op_arm) |=> irq);

    // R10: read data holds outside read accesses
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> $stable(bus_rdata));

    // chan_evt is an observed input only; kept for visibility of events
    logic unused_evt;
    assign unused_evt = ^chan_evt;
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_evt(chan_evt), .irq(irq), .cnt_run(cnt_run), .cnt_clr(cnt_clr)
);

// File: tb/sim_evt_irq_ctrl.sv
`timescale 1ns/1ps
module sim_evt_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] chan_evt = '0, idx_level = '0, cable_ok = '1;
    logic       irq, cnt_run, cnt_clr;

    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    evt_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .chan_evt(chan_evt), .idx_level(idx_level), .cable_ok(cable_ok),
        .irq(irq), .cnt_run(cnt_run), .cnt_clr(cnt_clr)
    );

    localparam logic [4:0] A_STAT = 5'h10, A_OP = 5'h11, A_EN = 5'h12,
                           A_IDX = 5'h16, A_CAB = 5'h17;

    // {enable mask, event mask, expected status}
    localparam int NV = 8;
    localparam logic [23:0] VEC [NV] = '{
        24'hFF_01_01, 24'hFF_A5_A5, 24'h0F_F0_00, 24'h0F_FF_0F,
        24'h81_81_81, 24'h00_FF_00, 24'h55_AA_00, 24'hF0_30_30
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk);
        chan_evt = m;
        @(negedge clk);
        chan_evt = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 cnt_run", {7'b0, cnt_run}, 8'h00);
        chk("R1 cnt_clr", {7'b0, cnt_clr}, 8'h00);
        rd(A_STAT, d); chk("R1 status", d, 8'h00);
        rd(A_EN, d);   chk("R1 enable", d, 8'h00);
        rd(A_CAB, d);  chk("R1 cable", d, 8'hFF);

        // R2: disarmed after reset, enabled event not latched
        wr(A_EN, 8'hFF);
        pulse(8'hFF);
        rd(A_STAT, d); chk("R2 disarmed no latch", d, 8'h00);

        // R4: arm
        wr(A_OP, 8'h04);
        chk("R4 cnt_run", {7'b0, cnt_run}, 8'h01);

        // R2/R3 vector table
        for (int k = 0; k < NV; k++) begin
            wr(A_EN, VEC[k][23:16]);
            rd(A_EN, d); chk("R9 enable readback", d, VEC[k][23:16]);
            pulse(VEC[k][15:8]);
            rd(A_STAT, d); chk("R2 status", d, VEC[k][7:0]);
            chk("R3 irq", {7'b0, irq}, {7'b0, |VEC[k][7:0]});
            pulse(8'h00);
            rd(A_STAT, d); chk("R2 sticky", d, VEC[k][7:0]);
            wr(A_OP, 8'h04);
            chk("R4 cleared irq", {7'b0, irq}, 8'h00);
            rd(A_STAT, d); chk("R4 cleared status", d, 8'h00);
        end

        // R5: disarm with a bit pending
        wr(A_EN, 8'hFF);
        pulse(8'h02);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = A_OP; bus_wdata = 8'h01;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
        chk("R5 cnt_clr pulse", {7'b0, cnt_clr}, 8'h01);
        chk("R5 cnt_run low", {7'b0, cnt_run}, 8'h00);
        @(negedge clk);
        chk("R5 cnt_clr one cycle", {7'b0, cnt_clr}, 8'h00);
        pulse(8'h04);
        rd(A_STAT, d); chk("R5 status kept, new ignored", d, 8'h02);
        chk("R5 irq kept", {7'b0, irq}, 8'h01);

        // R6: unknown op codes have no effect
        wr(A_OP, 8'h05);
        chk("R6 stays disarmed", {7'b0, cnt_run}, 8'h00);
        rd(A_STAT, d); chk("R6 status unchanged", d, 8'h02);
        wr(A_OP, 8'h04);
        wr(A_OP, 8'h00);
        wr(A_OP, 8'h02);
        chk("R6 stays armed", {7'b0, cnt_run}, 8'h01);
        pulse(8'h10);
        wr(A_OP, 8'hFF);
        rd(A_STAT, d); chk("R6 status kept", d, 8'h10);

        // R7: clear and event on the same edge
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = A_OP; bus_wdata = 8'h04; chan_evt = 8'h01;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; chan_evt = '0;
        rd(A_STAT, d); chk("R7 clear wins", d, 8'h00);
        pulse(8'h01);
        rd(A_STAT, d); chk("R7 later event latched", d, 8'h01);

        // R9: register map
        wr(A_STAT, 8'hFF);
        rd(A_STAT, d); chk("R9 status read-only", d, 8'h01);
        idx_level = 8'h5C;
        rd(A_IDX, d); chk("R9 index level", d, 8'h5C);
        rd(5'h14, d); chk("R9 reserved reads zero", d, 8'h00);
        wr(5'h03, 8'hAA);
        rd(5'h03, d); chk("R9 channel area zero", d, 8'h00);
        rd(A_OP, d);  chk("R9 op reads zero", d, 8'h00);

        // R8: cable monitoring
        cable_ok = 8'hF0;
        rd(A_CAB, d); chk("R8 all disabled", d, 8'hFF);
        wr(A_CAB, 8'h00);
        rd(A_CAB, d); chk("R8 all enabled", d, 8'hF0);
        wr(A_CAB, 8'hF3);
        rd(A_CAB, d); chk("R8 partial enable", d, 8'hF3);
        wr(A_CAB, 8'h0F);
        rd(A_CAB, d); chk("R8 faults masked", d, 8'hFF);

        // R10: read data holds between reads
        rd(A_IDX, held);
        idx_level = 8'h33;
        repeat (3) @(negedge clk);
        chk("R10 rdata held", bus_rdata, held);
        wr(A_EN, 8'h11);
        chk("R10 held over write", bus_rdata, held);

        finish_run();
    end
endmodule